// File: doc/BRIEF.md
# Power-Gating Domain Sequencer

This block walks the power domains of a four-pipe display engine in a fixed order and switches each one on or off through a single request/acknowledge handshake. A run starts with a one-cycle start pulse. At that pulse the block samples the direction, the per-pipe fetch and pixel request vectors, the per-engine compression request vector, the high-speed output request and the bypass input. Only one domain is ever being switched at a time. While the block waits, the identifier of that domain is shown on `step_dom_o`.

The root clocks of the pipe and compression domains are sequenced around the power steps. On a power-up run they are enabled before any power switch moves. On a power-down run they are removed only after the last power switch has settled. All enables are registers that keep their state between runs. A domain that a run does not visit therefore keeps its earlier value.

Top module: `pwr_domain_seq`

## Requirements
- R1: With `dir_up_i`=0, the requested domains are stepped in this order: high-speed output (id 25), pipes 0..3 (ids 0..3), compression engines 0..3 (ids 16..19), then the shared domain (id 24).
- R2: With `dir_up_i`=1, the order is exactly reversed: shared (24), compression 3..0 (19..16), pipes 3..0 (3..0), then high-speed output (25).
- R3: Pipe i is stepped only when both `fetch_req_i[i]` and `pix_req_i[i]` are 1.
- R4: The shared domain is stepped on every run that is not bypassed. Compression engine i and the high-speed output are stepped only when their own request bit is 1.
- R5: On a power-up run, the root clocks of the requested pipes (fetch and pixel both set) and compression engines are already 1 when the first power request is raised. These root clocks remain 1 after the run.
- R6: On a power-down run, the root clocks keep their old values during every power step. The clocks of the requested pipes and engines are 0 after done.
- R7: When `bypass_i` is 1 at the start pulse, no power request is raised and no power enable changes. The root clocks are still sequenced and done is still pulsed.
- R8: During a step, the domain's power enable already equals the target (1 for up, 0 for down) while `pwr_req_o` is 1. The request stays on one domain until an acknowledge or a timeout, and it drops in the cycle after `pwr_ack_i`.
- R9: If no acknowledge arrives, the request stays high for `tmo_limit_i`+1 cycles. `tmo_o` then sets and stays set until reset, and the run continues with the next step.
- R10: A start pulse while `busy_o` is 1 is ignored. `done_o` is a single-cycle pulse, and `busy_o` falls right after it.
- R11: Power enables never change while the block is idle. Domains that a run does not visit keep their previous values.
- R12: A skipped step takes one cycle. A power-down run with all request bits clear, where the acknowledge comes in the first request cycle, shows done on the 13th rising edge counted from the edge that samples start.
- R13: After reset, every power enable and root-clock enable is 1, and `busy_o`, `done_o`, `pwr_req_o` and `tmo_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when idle |
| dir_up_i | input | 1 | 1 = power up, 0 = power down |
| fetch_req_i | input | NPIPE | Per-pipe fetch-unit request |
| pix_req_i | input | NPIPE | Per-pipe pixel-processing request |
| cmp_req_i | input | NDSC | Per-engine compression request |
| hso_req_i | input | 1 | High-speed output request |
| bypass_i | input | 1 | Skip all power steps for this run |
| tmo_limit_i | input | TMO_W | Acknowledge wait limit in cycles |
| pwr_ack_i | input | 1 | Power-switch acknowledge |
| pwr_req_o | output | 1 | Power-switch request |
| step_dom_o | output | 5 | Identifier of the domain being switched |
| pipe_pwr_en_o | output | NPIPE | Pipe power enables |
| cmp_pwr_en_o | output | NDSC | Compression power enables |
| shr_pwr_en_o | output | 1 | Shared domain power enable |
| hso_pwr_en_o | output | 1 | High-speed output power enable |
| pipe_clk_en_o | output | NPIPE | Pipe root-clock enables |
| cmp_clk_en_o | output | NDSC | Compression root-clock enables |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| tmo_o | output | 1 | Sticky acknowledge-timeout flag |

## Verification
The hardest conditions to reach are a start pulse that lands in the middle of a long run and a timeout that must leave the rest of the sequence intact. The bench reaches the first by stretching acknowledges over several cycles and then pulsing start in the opposite direction with bypass set. Any effect of that pulse would show up as a changed step list or changed enables. It reaches the second by withholding the acknowledge with a small wait limit, both in a directed run and in some random runs. The bench counts how long the request stays high, and it checks that the later steps still happen in the right order.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int DOM_W = 5;
    localparam logic [DOM_W-1:0] DOM_PIPE_BASE = 5'd0;
    localparam logic [DOM_W-1:0] DOM_CMP_BASE  = 5'd16;
    localparam logic [DOM_W-1:0] DOM_SHR       = 5'd24;
    localparam logic [DOM_W-1:0] DOM_HSO       = 5'd25;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_ON,
        ST_STEP,
        ST_WAIT,
        ST_CLK_OFF,
        ST_FIN
    } seq_st_e;

    typedef enum logic [1:0] {
        DK_PIPE,
        DK_CMP,
        DK_SHR,
        DK_HSO
    } dom_kind_e;

endpackage

// File: rtl/pwr_seq_order.sv
// Maps a step position and direction onto a domain and its request state.
module pwr_seq_order
    import pwr_seq_pkg::*;
#(
    parameter int NPIPE  = 4,
    parameter int NDSC   = 4,
    parameter int STEP_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic              up_i,
    input  logic [NPIPE-1:0]  pipe_sel_i,
    input  logic [NDSC-1:0]   cmp_sel_i,
    input  logic              hso_sel_i,
    output dom_kind_e         kind_o,
    output logic [IDX_W-1:0]  unit_o,
    output logic [DOM_W-1:0]  dom_o,
    output logic              active_o
);
    localparam int NSTEP = NPIPE + NDSC + 2;
    localparam logic [STEP_W-1:0] LAST     = STEP_W'(NSTEP - 1);
    localparam logic [STEP_W-1:0] PIPE_END = STEP_W'(NPIPE);
    localparam logic [STEP_W-1:0] CMP_END  = STEP_W'(NPIPE + NDSC);

    logic [STEP_W-1:0] pos;

    always_comb begin
        // power-down walks forward, power-up walks the same list backwards
        pos    = up_i ? (LAST - step_i) : step_i;
        kind_o = DK_SHR;
        unit_o = '0;
        if (pos == '0) begin
            kind_o = DK_HSO;
        end else if (pos <= PIPE_END) begin
            kind_o = DK_PIPE;
            unit_o = IDX_W'(pos - 1'b1);
        end else if (pos <= CMP_END) begin
            kind_o = DK_CMP;
            unit_o = IDX_W'(pos - PIPE_END - 1'b1);
        end
    end

    always_comb begin
        case (kind_o)
            DK_PIPE: begin
                dom_o    = DOM_PIPE_BASE + DOM_W'(unit_o);
                active_o = pipe_sel_i[unit_o];
            end
            DK_CMP: begin
                dom_o    = DOM_CMP_BASE + DOM_W'(unit_o);
                active_o = cmp_sel_i[unit_o];
            end
            DK_HSO: begin
                dom_o    = DOM_HSO;
                active_o = hso_sel_i;
            end
            default: begin
                dom_o    = DOM_SHR;
                active_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pwr_seq_timer.sv
// Acknowledge wait counter; expires once the count reaches the limit.
module pwr_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = run_i && (cnt_q == limit_i);

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pwr_seq_pkg::*;
#(
    parameter int NPIPE = 4,
    parameter int NDSC  = 4,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_up_i,
    input  logic [NPIPE-1:0] fetch_req_i,
    input  logic [NPIPE-1:0] pix_req_i,
    input  logic [NDSC-1:0]  cmp_req_i,
    input  logic             hso_req_i,
    input  logic             bypass_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    input  logic             pwr_ack_i,
    output logic             pwr_req_o,
    output logic [4:0]       step_dom_o,
    output logic [NPIPE-1:0] pipe_pwr_en_o,
    output logic [NDSC-1:0]  cmp_pwr_en_o,
    output logic             shr_pwr_en_o,
    output logic             hso_pwr_en_o,
    output logic [NPIPE-1:0] pipe_clk_en_o,
    output logic [NDSC-1:0]  cmp_clk_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             tmo_o
);
    localparam int NSTEP  = NPIPE + NDSC + 2;
    localparam int STEP_W = $clog2(NSTEP);
    localparam int MAXU   = (NPIPE > NDSC) ? NPIPE : NDSC;
    localparam int IDX_W  = (MAXU > 1) ? $clog2(MAXU) : 1;
    localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEP - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] step;
        logic              up;
        logic              byp;
        logic [NPIPE-1:0]  psel;
        logic [NDSC-1:0]   csel;
        logic              hsel;
        logic [NPIPE-1:0]  ppwr;
        logic [NDSC-1:0]   cpwr;
        logic              spwr;
        logic              hpwr;
        logic [NPIPE-1:0]  pclk;
        logic [NDSC-1:0]   cclk;
        logic              req;
        logic              tmo;
    } seq_t;

    seq_t r_d, r_q;

    dom_kind_e        o_kind;
    logic [IDX_W-1:0] o_unit;
    logic [DOM_W-1:0] o_dom;
    logic             o_active;
    logic             t_clr, t_run, t_exp;

    pwr_seq_order #(
        .NPIPE (NPIPE),
        .NDSC  (NDSC),
        .STEP_W(STEP_W),
        .IDX_W (IDX_W)
    ) i_order (
        .step_i    (r_q.step),
        .up_i      (r_q.up),
        .pipe_sel_i(r_q.psel),
        .cmp_sel_i (r_q.csel),
        .hso_sel_i (r_q.hsel),
        .kind_o    (o_kind),
        .unit_o    (o_unit),
        .dom_o     (o_dom),
        .active_o  (o_active)
    );

    pwr_seq_timer #(
        .CNT_W(TMO_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (t_clr),
        .run_i   (t_run),
        .limit_i (tmo_limit_i),
        .expire_o(t_exp)
    );

    always_comb begin
        logic adv;
        r_d   = r_q;
        t_clr = 1'b0;
        t_run = 1'b0;
        adv   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.up   = dir_up_i;
                    r_d.byp  = bypass_i;
                    r_d.psel = fetch_req_i & pix_req_i;
                    r_d.csel = cmp_req_i;
                    r_d.hsel = hso_req_i;
                    r_d.step = '0;
                    if (dir_up_i)      r_d.st = ST_CLK_ON;
                    else if (bypass_i) r_d.st = ST_CLK_OFF;
                    else               r_d.st = ST_STEP;
                end
            end
            ST_CLK_ON: begin
                r_d.pclk = r_q.pclk | r_q.psel;
                r_d.cclk = r_q.cclk | r_q.csel;
                r_d.st   = r_q.byp ? ST_FIN : ST_STEP;
            end
            ST_STEP: begin
                if (o_active) begin
                    case (o_kind)
                        DK_PIPE: r_d.ppwr[o_unit] = r_q.up;
                        DK_CMP:  r_d.cpwr[o_unit] = r_q.up;
                        DK_HSO:  r_d.hpwr         = r_q.up;
                        default: r_d.spwr         = r_q.up;
                    endcase
                    r_d.req = 1'b1;
                    r_d.st  = ST_WAIT;
                    t_clr   = 1'b1;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_WAIT: begin
                t_run = 1'b1;
                if (pwr_ack_i || t_exp) begin
                    r_d.req = 1'b0;
                    if (!pwr_ack_i) r_d.tmo = 1'b1;
                    adv = 1'b1;
                end
            end
            ST_CLK_OFF: begin
                r_d.pclk = r_q.pclk & ~r_q.psel;
                r_d.cclk = r_q.cclk & ~r_q.csel;
                r_d.st   = ST_FIN;
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (adv) begin
            if (r_q.step == LAST) begin
                r_d.st = r_q.up ? ST_FIN : ST_CLK_OFF;
            end else begin
                r_d.step = r_q.step + 1'b1;
                r_d.st   = ST_STEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.ppwr <= '1;
            r_q.cpwr <= '1;
            r_q.spwr <= 1'b1;
            r_q.hpwr <= 1'b1;
            r_q.pclk <= '1;
            r_q.cclk <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign pwr_req_o     = r_q.req;
    assign step_dom_o    = o_dom;
    assign pipe_pwr_en_o = r_q.ppwr;
    assign cmp_pwr_en_o  = r_q.cpwr;
    assign shr_pwr_en_o  = r_q.spwr;
    assign hso_pwr_en_o  = r_q.hpwr;
    assign pipe_clk_en_o = r_q.pclk;
    assign cmp_clk_en_o  = r_q.cclk;
    assign busy_o        = (r_q.st != ST_IDLE);
    assign done_o        = (r_q.st == ST_FIN);
    assign tmo_o         = r_q.tmo;

endmodule

// File: rtl/pwr_domain_seq_chk.sv
module pwr_domain_seq_chk #(
    parameter int NPIPE = 4,
    parameter int NDSC  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic             pwr_req_o,
    input logic             pwr_ack_i,
    input logic             tmo_o,
    input logic [4:0]       step_dom_o,
    input logic [NPIPE-1:0] pipe_pwr_en_o,
    input logic [NDSC-1:0]  cmp_pwr_en_o,
    input logic             shr_pwr_en_o,
    input logic             hso_pwr_en_o
);
    // R8
    req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_req_o |-> busy_o);

    // R8
    ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_req_o && pwr_ack_i) |=> !pwr_req_o);

    // R8
    dom_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_req_o && $past(pwr_req_o)) |-> $stable(step_dom_o));

    // R9
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |=> tmo_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(pipe_pwr_en_o) && $stable(cmp_pwr_en_o)
                     && $stable(shr_pwr_en_o) && $stable(hso_pwr_en_o)));

endmodule

bind pwr_domain_seq pwr_domain_seq_chk #(
    .NPIPE(NPIPE),
    .NDSC (NDSC)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pwr_req_o    (pwr_req_o),
    .pwr_ack_i    (pwr_ack_i),
    .tmo_o        (tmo_o),
    .step_dom_o   (step_dom_o),
    .pipe_pwr_en_o(pipe_pwr_en_o),
    .cmp_pwr_en_o (cmp_pwr_en_o),
    .shr_pwr_en_o (shr_pwr_en_o),
    .hso_pwr_en_o (hso_pwr_en_o)
);

// File: tb/test_pwr_domain_seq.sv
module test_pwr_domain_seq;
    localparam int NP = 4;
    localparam int NC = 4;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          start_i = 0, dir_up_i = 0, hso_req_i = 0, bypass_i = 0, pwr_ack_i = 0;
    logic [NP-1:0] fetch_req_i = '0, pix_req_i = '0;
    logic [NC-1:0] cmp_req_i = '0;
    logic [TW-1:0] tmo_limit_i = 8'd4;
    logic          pwr_req_o, shr_pwr_en_o, hso_pwr_en_o, busy_o, done_o, tmo_o;
    logic [4:0]    step_dom_o;
    logic [NP-1:0] pipe_pwr_en_o, pipe_clk_en_o;
    logic [NC-1:0] cmp_pwr_en_o, cmp_clk_en_o;

    pwr_domain_seq #(.NPIPE(NP), .NDSC(NC), .TMO_W(TW)) i_pwr_domain_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_up_i(dir_up_i),
        .fetch_req_i(fetch_req_i), .pix_req_i(pix_req_i), .cmp_req_i(cmp_req_i),
        .hso_req_i(hso_req_i), .bypass_i(bypass_i), .tmo_limit_i(tmo_limit_i),
        .pwr_ack_i(pwr_ack_i), .pwr_req_o(pwr_req_o), .step_dom_o(step_dom_o),
        .pipe_pwr_en_o(pipe_pwr_en_o), .cmp_pwr_en_o(cmp_pwr_en_o),
        .shr_pwr_en_o(shr_pwr_en_o), .hso_pwr_en_o(hso_pwr_en_o),
        .pipe_clk_en_o(pipe_clk_en_o), .cmp_clk_en_o(cmp_clk_en_o),
        .busy_o(busy_o), .done_o(done_o), .tmo_o(tmo_o)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // reference model of the registered enables
    logic [NP-1:0] m_ppwr = '1, m_pclk = '1;
    logic [NC-1:0] m_cpwr = '1, m_cclk = '1;
    logic          m_spwr = 1, m_hpwr = 1, m_tmo = 0;

    int exp_ids[16];
    int exp_n;

    function automatic void build_exp(bit up, logic [NP-1:0] ps, logic [NC-1:0] cs, bit hs, bit byp);
        int lst[16];
        int n = 0;
        if (hs) begin lst[n] = 25; n++; end
        for (int i = 0; i < NP; i++) if (ps[i]) begin lst[n] = i; n++; end
        for (int i = 0; i < NC; i++) if (cs[i]) begin lst[n] = 16 + i; n++; end
        lst[n] = 24; n++;
        exp_n = byp ? 0 : n;
        for (int k = 0; k < n; k++) exp_ids[k] = up ? lst[n-1-k] : lst[k];
    endfunction

    function automatic int dom_en(int id);
        if (id < 16)       return int'(pipe_pwr_en_o[id]);
        else if (id < 24)  return int'(cmp_pwr_en_o[id-16]);
        else if (id == 24) return int'(shr_pwr_en_o);
        else               return int'(hso_pwr_en_o);
    endfunction

    function automatic void model_set(int id, bit v);
        if (id < 16)       m_ppwr[id] = v;
        else if (id < 24)  m_cpwr[id-16] = v;
        else if (id == 24) m_spwr = v;
        else               m_hpwr = v;
    endfunction

    // monitor and acknowledge responder
    int obs_ids[32], obs_en[32], obs_clk[32];
    int obs_n = 0, hi_cnt = 0, wcnt = 0, ack_dly = 0;
    bit ack_never = 0, prev_req = 0;

    initial forever begin
        @(negedge clk);
        if (pwr_req_o && !prev_req) begin
            if (obs_n < 32) begin
                obs_ids[obs_n] = int'(step_dom_o);
                obs_en[obs_n]  = dom_en(int'(step_dom_o));
                obs_clk[obs_n] = int'({cmp_clk_en_o, pipe_clk_en_o});
            end
            obs_n++;
            hi_cnt = 1;
            wcnt = 0;
        end else if (pwr_req_o) begin
            hi_cnt++;
        end
        prev_req = pwr_req_o;
        if (pwr_ack_i) pwr_ack_i = 0;
        else if (pwr_req_o && !ack_never) begin
            if (wcnt >= ack_dly) pwr_ack_i = 1;
            else wcnt++;
        end
    end

    task automatic run_seq(bit up, logic [NP-1:0] fch, logic [NP-1:0] pix, logic [NC-1:0] cmp,
                           bit hso, bit byp, int dly, bit never, int lim, bit poke,
                           string tag, output int cyc);
        logic [NP-1:0] ps;
        int old_clk, new_clk;
        string tg;
        ps = fch & pix;
        old_clk = int'({m_cclk, m_pclk});
        new_clk = up ? int'({m_cclk | cmp, m_pclk | ps}) : int'({m_cclk & ~cmp, m_pclk & ~ps});
        build_exp(up, ps, cmp, hso, byp);
        tg = (tag != "") ? tag : (up ? "R2" : "R1");
        dir_up_i = up; fetch_req_i = fch; pix_req_i = pix; cmp_req_i = cmp;
        hso_req_i = hso; bypass_i = byp; tmo_limit_i = TW'(lim);
        ack_dly = dly; ack_never = never; obs_n = 0;
        start_i = 1;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 1) start_i = 0;
            if (done_o) break;
            if (poke && cyc == 3) begin start_i = 1; dir_up_i = !up; bypass_i = 1; end
            if (poke && cyc == 4) begin start_i = 0; bypass_i = 0; end
            if (cyc > 3000) begin
                chk(0, tg, "run never finished", cyc, 0);
                break;
            end
        end
        chk(obs_n == exp_n, tg, "step count", obs_n, exp_n);
        for (int k = 0; k < exp_n && k < obs_n && k < 32; k++) begin
            chk(obs_ids[k] == exp_ids[k], tg, "domain id in order", obs_ids[k], exp_ids[k]);
            chk(obs_en[k] == int'(up), "R8", "enable during request", obs_en[k], int'(up));
            if (up) chk(obs_clk[k] == new_clk, "R5", "root clocks before power step", obs_clk[k], new_clk);
            else    chk(obs_clk[k] == old_clk, "R6", "root clocks during power step", obs_clk[k], old_clk);
        end
        if (byp) chk(obs_n == 0, "R7", "requests under bypass", obs_n, 0);
        if (!byp) begin
            for (int k = 0; k < exp_n; k++) model_set(exp_ids[k], up);
            if (never) m_tmo = 1;
        end
        if (up) begin m_pclk = m_pclk | ps; m_cclk = m_cclk | cmp; end
        else    begin m_pclk = m_pclk & ~ps; m_cclk = m_cclk & ~cmp; end
        @(negedge clk);
        chk(done_o == 0, "R10", "done pulse width", int'(done_o), 0);
        chk(busy_o == 0, "R10", "busy after done", int'(busy_o), 0);
        chk({hso_pwr_en_o, shr_pwr_en_o, cmp_pwr_en_o, pipe_pwr_en_o} == {m_hpwr, m_spwr, m_cpwr, m_ppwr},
            "R11", "power enables after run",
            int'({hso_pwr_en_o, shr_pwr_en_o, cmp_pwr_en_o, pipe_pwr_en_o}),
            int'({m_hpwr, m_spwr, m_cpwr, m_ppwr}));
        chk(int'({cmp_clk_en_o, pipe_clk_en_o}) == new_clk, up ? "R5" : "R6", "root clocks after run",
            int'({cmp_clk_en_o, pipe_clk_en_o}), new_clk);
        chk(tmo_o == m_tmo, "R9", "timeout flag", int'(tmo_o), int'(m_tmo));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int cyc;
        int dummy;
        int dones;
        dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        chk({pipe_pwr_en_o, cmp_pwr_en_o, shr_pwr_en_o, hso_pwr_en_o} == '1, "R13", "power enables",
            int'({pipe_pwr_en_o, cmp_pwr_en_o, shr_pwr_en_o, hso_pwr_en_o}), 1023);
        chk({pipe_clk_en_o, cmp_clk_en_o} == '1, "R13", "root clocks",
            int'({pipe_clk_en_o, cmp_clk_en_o}), 255);
        chk({busy_o, done_o, pwr_req_o, tmo_o} == 4'b0, "R13", "status outputs",
            int'({busy_o, done_o, pwr_req_o, tmo_o}), 0);

        // R12 latency of a run where every optional step is skipped
        run_seq(0, '0, '0, '0, 0, 0, 0, 0, 4, 0, "R12", cyc);
        chk(cyc == 13, "R12", "cycles to done", cyc, 13);

        // R9 timeout with the acknowledge withheld
        chk(tmo_o == 0, "R9", "flag clear before timeout", int'(tmo_o), 0);
        run_seq(0, '0, '0, '0, 0, 0, 0, 1, 3, 0, "R9", cyc);
        chk(hi_cnt == 4, "R9", "request cycles before timeout", hi_cnt, 4);

        // power everything up, then partial patterns
        run_seq(1, '1, '1, '1, 1, 0, 1, 0, 8, 0, "R2", cyc);
        run_seq(0, 4'b1011, 4'b0111, '0, 0, 0, 0, 0, 8, 0, "R3", cyc);
        run_seq(0, '0, '0, 4'b0101, 1, 0, 2, 0, 8, 0, "R4", cyc);
        run_seq(1, 4'b0100, 4'b1100, 4'b0001, 0, 0, 0, 0, 8, 0, "R4", cyc);
        run_seq(0, '1, '1, '1, 1, 0, 0, 0, 8, 0, "R1", cyc);

        // R7 bypass: clocks move, power enables do not
        run_seq(1, '1, '1, '1, 1, 1, 0, 0, 8, 0, "R7", cyc);
        run_seq(0, 4'b0011, 4'b0011, 4'b1000, 0, 1, 0, 0, 8, 0, "R7", cyc);

        // R10 start pulse in the middle of a run
        run_seq(1, '1, '1, '1, 1, 0, 2, 0, 8, 1, "R10", cyc);
        dones = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done_o || busy_o) dones++;
        end
        chk(dones == 0, "R10", "no extra run after ignored start", dones, 0);

        // constrained random runs
        for (int r = 0; r < 60; r++) begin
            bit up, byp, nev;
            logic [NP-1:0] f, p;
            logic [NC-1:0] c;
            up  = 1'($urandom % 2);
            byp = (($urandom % 6) == 0);
            nev = (($urandom % 8) == 0);
            f   = NP'($urandom);
            p   = NP'($urandom);
            c   = NC'($urandom);
            run_seq(up, f, p, c, 1'($urandom % 2), byp, int'($urandom % 4), nev,
                    int'($urandom % 6), 0, "", cyc);
        end

        summary();
        $finish;
    end

endmodule